// File: doc/BRIEF.md
# NAND Slot Bus Bridge

This block joins a processor's strobe-driven external bus to two NAND flash slots and a small register window. Each bus cycle is sampled on the block clock. Upper address bits choose the target: flash slot 0, flash slot 1, or the register window. On a flash write, two low address bits give the byte its role: command byte, address byte, or plain data byte. One bus write therefore carries both the byte and its latch role, with no separate control register to program first.

Flash-side pins (chip enables, the two latch enables, the write and read enables, and the data driver) are registered copies of the decoded bus cycle, one clock behind the bus. Flash reads return the byte on the low half of the 16-bit read bus. A status word in the register window shows the synchronized ready/busy line of the slot that was accessed most recently. The bus has no valid/ready handshake and no back-pressure. The processor side sets its own wait states so that every strobe lasts long enough for the registered pins and the one-clock read latency.

Top module: `nsb_bridge`

## Requirements
- R1: With chip select active, address bits 24..22 equal to 3'b010 select flash slot 0 (nand_ce_n[0] low) and 3'b011 select flash slot 1 (nand_ce_n[1] low). The enable appears one clock after the bus cycle is sampled.
- R2: At most one nand_ce_n bit is low at any time. None is low when chip select is inactive, for the register code 3'b100, or for any other code.
- R3: A flash write with address bit 5 set drives nand_cle high and nand_ale low.
- R4: A flash write with address bit 4 set and bit 5 clear drives nand_ale high. When both bits are set, the command role wins: only nand_cle is high.
- R5: A flash write with both bits 5 and 4 clear is a data write. nand_cle and nand_ale stay low while nand_we_n is low.
- R6: nand_we_n is low for each clock in which a flash write is sampled, and nand_re_n is low for each clock in which a flash read is sampled. The write strobe wins if both are active, so the two are never low together.
- R7: During a flash write, nand_dq_out carries bus_wdata and nand_dq_oe is high. For one clock after nand_we_n rises, nand_dq_oe stays high and nand_dq_out is unchanged.
- R8: A flash read puts {8'h00, nand_dq_in} on bus_rdata one clock later. A register-window read at any offset other than 2 returns zero.
- R9: A read of the register window at offset 0x2 (address bits 21..0) returns bit 0 equal to the ready/busy line of the most recently accessed slot, where 1 means ready, and zeros in bits 15..1. A change on nand_rb reaches bus_rdata on the third clock edge.
- R10: During reset, all nand_ce_n bits are high, nand_we_n and nand_re_n are high, nand_cle, nand_ale and nand_dq_oe are low, bus_rdata is zero, and slot 0 is the current slot.
- R11: A write to the register window leaves all flash pins idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cs_n | input | 1 | Bus chip select, active low |
| bus_wr_n | input | 1 | Bus write strobe, active low |
| bus_rd_n | input | 1 | Bus read strobe, active low |
| bus_addr | input | 25 | Bus address |
| bus_wdata | input | 8 | Write byte (low byte of the bus) |
| bus_rdata | output | 16 | Read data, registered |
| nand_ce_n | output | 2 | Per-slot flash chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Flash write enable, active low |
| nand_re_n | output | 1 | Flash read enable, active low |
| nand_dq_out | output | 8 | Byte driven toward the flash |
| nand_dq_oe | output | 1 | Output enable for nand_dq_out |
| nand_dq_in | input | 8 | Byte read from the flash |
| nand_rb | input | 2 | Per-slot ready/busy, 1 means ready |

## Verification
The hardest case to reach from the ports is the status bit following one slot's ready/busy line while the other slot's line differs. The bench holds the two slots at opposite levels and moves the current slot back and forth with single flash accesses before each status read. It then toggles the current slot's line while a status read is held, and checks that the old value is still seen after one and two edges and the new value after three. The data hold cycle after a write is checked in the same directed way, on the clocks after the write strobe drops.

// File: rtl/nsb_pkg.sv
package nsb_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_FLASH = 2'd1,
    TGT_REGS  = 2'd2
  } nsb_tgt_e;
endpackage

// File: rtl/nsb_decode.sv
module nsb_decode
  import nsb_pkg::*;
#(
  parameter int ADDR_W     = 25,
  parameter int SEL_LSB    = 22,
  parameter int SEL_W      = 3,
  parameter int NUM_SLOTS  = 2,
  parameter int SLOT_BASE  = 2,
  parameter int REG_CODE   = 4,
  parameter int CLE_BIT    = 5,
  parameter int ALE_BIT    = 4,
  parameter int STATUS_OFS = 2,
  localparam int SLOT_IW   = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic               cs_n,
  input  logic               wr_n,
  input  logic               rd_n,
  input  logic [ADDR_W-1:0]  addr,
  output nsb_tgt_e           tgt,
  output logic [SLOT_IW-1:0] slot_idx,
  output logic               is_wr,
  output logic               is_rd,
  output logic               is_status,
  output logic               want_cle,
  output logic               want_ale
);
  logic [SEL_W-1:0] sel;

  assign sel = addr[SEL_LSB +: SEL_W];

  always_comb begin
    tgt      = TGT_NONE;
    slot_idx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (sel == SEL_W'(SLOT_BASE + i)) begin
        tgt      = TGT_FLASH;
        slot_idx = SLOT_IW'(i);
      end
    end
    if (sel == SEL_W'(REG_CODE)) tgt = TGT_REGS;
    if (cs_n) tgt = TGT_NONE;
  end

  // the write strobe takes precedence over a simultaneous read strobe
  assign is_wr     = !cs_n && !wr_n;
  assign is_rd     = !cs_n && !rd_n && wr_n;
  assign is_status = (addr[SEL_LSB-1:0] == SEL_LSB'(STATUS_OFS));
  assign want_cle  = addr[CLE_BIT];
  assign want_ale  = addr[ALE_BIT] && !addr[CLE_BIT];
endmodule

// File: rtl/nsb_rb_sync.sv
module nsb_rb_sync #(
  parameter int NUM_SLOTS = 2,
  parameter int STAGES    = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] rb_async,
  output logic [NUM_SLOTS-1:0] rb_sync
);
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    logic [STAGES-1:0] shift_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) shift_q <= '0;
      else        shift_q <= {shift_q[STAGES-2:0], rb_async[g]};
    end

    assign rb_sync[g] = shift_q[STAGES-1];
  end
endmodule

// File: rtl/nsb_strobe.sv
module nsb_strobe
  import nsb_pkg::*;
#(
  parameter int NUM_SLOTS = 2,
  parameter int DQ_W      = 8,
  localparam int SLOT_IW  = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  nsb_tgt_e             tgt,
  input  logic [SLOT_IW-1:0]   slot_idx,
  input  logic                 is_wr,
  input  logic                 is_rd,
  input  logic                 want_cle,
  input  logic                 want_ale,
  input  logic [DQ_W-1:0]      wdata,
  output logic [NUM_SLOTS-1:0] ce_n,
  output logic                 cle,
  output logic                 ale,
  output logic                 we_n,
  output logic                 re_n,
  output logic [DQ_W-1:0]      dq_out,
  output logic                 dq_oe
);
  logic                 flash_wr, flash_rd;
  logic [NUM_SLOTS-1:0] ce_n_nxt;

  assign flash_wr = (tgt == TGT_FLASH) && is_wr;
  assign flash_rd = (tgt == TGT_FLASH) && is_rd;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++)
      ce_n_nxt[i] = !((tgt == TGT_FLASH) && (slot_idx == SLOT_IW'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_n   <= '1;
      cle    <= 1'b0;
      ale    <= 1'b0;
      we_n   <= 1'b1;
      re_n   <= 1'b1;
      dq_out <= '0;
      dq_oe  <= 1'b0;
    end else begin
      ce_n  <= ce_n_nxt;
      cle   <= flash_wr && want_cle;
      ale   <= flash_wr && want_ale;
      we_n  <= !flash_wr;
      re_n  <= !flash_rd;
      // keep driving for one clock after the write enable goes high
      dq_oe <= flash_wr || !we_n;
      if (flash_wr) dq_out <= wdata;
    end
  end

  // R2
  one_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~ce_n) <= 1);
  // R2
  strobe_needs_ce_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!we_n || !re_n) |-> (ce_n != '1));
  // R6
  we_re_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !re_n));
  // R4
  cle_ale_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(cle && ale));
  // R7
  dq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(we_n) |-> (dq_oe && $stable(dq_out)));
endmodule

// File: rtl/nsb_bridge.sv
module nsb_bridge
  import nsb_pkg::*;
#(
  parameter int ADDR_W      = 25,
  parameter int SEL_LSB     = 22,
  parameter int SEL_W       = 3,
  parameter int NUM_SLOTS   = 2,
  parameter int SLOT_BASE   = 2,
  parameter int REG_CODE    = 4,
  parameter int CLE_BIT     = 5,
  parameter int ALE_BIT     = 4,
  parameter int STATUS_OFS  = 2,
  parameter int REG_W       = 16,
  parameter int DQ_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_cs_n,
  input  logic                 bus_wr_n,
  input  logic                 bus_rd_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DQ_W-1:0]      bus_wdata,
  output logic [REG_W-1:0]     bus_rdata,
  output logic [NUM_SLOTS-1:0] nand_ce_n,
  output logic                 nand_cle,
  output logic                 nand_ale,
  output logic                 nand_we_n,
  output logic                 nand_re_n,
  output logic [DQ_W-1:0]      nand_dq_out,
  output logic                 nand_dq_oe,
  input  logic [DQ_W-1:0]      nand_dq_in,
  input  logic [NUM_SLOTS-1:0] nand_rb
);
  localparam int SLOT_IW = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

  nsb_tgt_e             tgt;
  logic [SLOT_IW-1:0]   slot_idx;
  logic                 is_wr, is_rd, is_status, want_cle, want_ale;
  logic [NUM_SLOTS-1:0] rb_sync;
  logic [SLOT_IW-1:0]   cur_slot;

  nsb_decode #(
    .ADDR_W(ADDR_W), .SEL_LSB(SEL_LSB), .SEL_W(SEL_W), .NUM_SLOTS(NUM_SLOTS),
    .SLOT_BASE(SLOT_BASE), .REG_CODE(REG_CODE), .CLE_BIT(CLE_BIT),
    .ALE_BIT(ALE_BIT), .STATUS_OFS(STATUS_OFS)
  ) decode_i (
    .cs_n(bus_cs_n), .wr_n(bus_wr_n), .rd_n(bus_rd_n), .addr(bus_addr),
    .tgt(tgt), .slot_idx(slot_idx), .is_wr(is_wr), .is_rd(is_rd),
    .is_status(is_status), .want_cle(want_cle), .want_ale(want_ale)
  );

  nsb_strobe #(.NUM_SLOTS(NUM_SLOTS), .DQ_W(DQ_W)) strobe_i (
    .clk(clk), .rst_n(rst_n), .tgt(tgt), .slot_idx(slot_idx),
    .is_wr(is_wr), .is_rd(is_rd), .want_cle(want_cle), .want_ale(want_ale),
    .wdata(bus_wdata), .ce_n(nand_ce_n), .cle(nand_cle), .ale(nand_ale),
    .we_n(nand_we_n), .re_n(nand_re_n), .dq_out(nand_dq_out),
    .dq_oe(nand_dq_oe)
  );

  nsb_rb_sync #(.NUM_SLOTS(NUM_SLOTS), .STAGES(SYNC_STAGES)) rb_sync_i (
    .clk(clk), .rst_n(rst_n), .rb_async(nand_rb), .rb_sync(rb_sync)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_slot  <= '0;
      bus_rdata <= '0;
    end else begin
      if (tgt == TGT_FLASH) cur_slot <= slot_idx;
      if ((tgt == TGT_FLASH) && is_rd)
        bus_rdata <= REG_W'(nand_dq_in);
      else if ((tgt == TGT_REGS) && is_rd && is_status)
        bus_rdata <= REG_W'(rb_sync[cur_slot]);
      else
        bus_rdata <= '0;
    end
  end

  // R11
  reg_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_REGS) |=> ((nand_ce_n == '1) && nand_we_n && nand_re_n));
  // R2
  no_target_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_cs_n |=> (nand_ce_n == '1));
  // R9
  status_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt == TGT_REGS) |=> (bus_rdata[REG_W-1:1] == '0));
endmodule

// File: tb/nsb_bridge_tb.sv
module nsb_bridge_tb_top;
  localparam int CLK_P = 10;
  localparam logic [24:0] A_S0  = 25'h0800000;
  localparam logic [24:0] A_S1  = 25'h0C00000;
  localparam logic [24:0] A_REG = 25'h1000000;

  typedef struct packed {
    logic        cs_n;
    logic        wr_n;
    logic        rd_n;
    logic [24:0] addr;
    logic [7:0]  wd;
    logic [1:0]  ce_n;
    logic        cle;
    logic        ale;
    logic        we_n;
    logic        re_n;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b1, A_S0 | 25'h20,  8'hA5, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1}, // R1 R3
    '{1'b0, 1'b0, 1'b1, A_S1 | 25'h10,  8'h3C, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1}, // R1 R4
    '{1'b0, 1'b0, 1'b1, A_S0 | 25'h30,  8'h81, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1}, // R4
    '{1'b0, 1'b0, 1'b1, A_S1,           8'h77, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1}, // R5
    '{1'b0, 1'b1, 1'b0, A_S0 | 25'h20,  8'h00, 2'b10, 1'b0, 1'b0, 1'b1, 1'b0}, // R6
    '{1'b0, 1'b0, 1'b1, A_REG | 25'h2,  8'h12, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1}, // R11
    '{1'b1, 1'b0, 1'b1, A_S0 | 25'h20,  8'h44, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1}, // R2
    '{1'b0, 1'b0, 1'b1, 25'h0400000,    8'h55, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1}, // R2
    '{1'b0, 1'b1, 1'b0, 25'h1400000,    8'h00, 2'b11, 1'b0, 1'b0, 1'b1, 1'b1}, // R2
    '{1'b0, 1'b0, 1'b0, A_S1,           8'h9E, 2'b01, 1'b0, 1'b0, 1'b0, 1'b1}  // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_cs_n = 1'b1, bus_wr_n = 1'b1, bus_rd_n = 1'b1;
  logic [24:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic [1:0]  nand_ce_n;
  logic        nand_cle, nand_ale, nand_we_n, nand_re_n, nand_dq_oe;
  logic [7:0]  nand_dq_out;
  logic [7:0]  nand_dq_in = 8'h00;
  logic [1:0]  nand_rb = 2'b01;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  nsb_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
    .bus_rd_n(bus_rd_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .nand_ce_n(nand_ce_n), .nand_cle(nand_cle),
    .nand_ale(nand_ale), .nand_we_n(nand_we_n), .nand_re_n(nand_re_n),
    .nand_dq_out(nand_dq_out), .nand_dq_oe(nand_dq_oe),
    .nand_dq_in(nand_dq_in), .nand_rb(nand_rb)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic cs_n, input logic wr_n, input logic rd_n,
                       input logic [24:0] addr, input logic [7:0] wd);
    bus_cs_n  = cs_n;
    bus_wr_n  = wr_n;
    bus_rd_n  = rd_n;
    bus_addr  = addr;
    bus_wdata = wd;
  endtask

  task automatic idle();
    drive(1'b1, 1'b1, 1'b1, '0, '0);
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state while reset is held
    chk(nand_ce_n == 2'b11 && nand_we_n && nand_re_n && !nand_cle && !nand_ale
        && !nand_dq_oe && bus_rdata == 16'h0, "R10 reset pins",
        {nand_ce_n, nand_we_n, nand_re_n, nand_cle, nand_ale, nand_dq_oe},
        7'b1111000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9 current slot is 0 after reset; slot 0 is ready
    drive(1'b0, 1'b1, 1'b0, A_REG | 25'h2, 8'h00);
    @(negedge clk);
    chk(bus_rdata == 16'h0001, "R9 status after reset", bus_rdata, 16'h0001);
    idle();
    @(negedge clk);

    // table walk: one bus cycle per entry, pins checked one clock later
    for (int v = 0; v < NV; v++) begin
      drive(VECS[v].cs_n, VECS[v].wr_n, VECS[v].rd_n, VECS[v].addr, VECS[v].wd);
      @(negedge clk);
      chk(nand_ce_n == VECS[v].ce_n, $sformatf("R1/R2 ce vec%0d", v),
          nand_ce_n, VECS[v].ce_n);
      chk({nand_cle, nand_ale} == {VECS[v].cle, VECS[v].ale},
          $sformatf("R3/R4/R5 latch vec%0d", v), {nand_cle, nand_ale},
          {VECS[v].cle, VECS[v].ale});
      chk({nand_we_n, nand_re_n} == {VECS[v].we_n, VECS[v].re_n},
          $sformatf("R6/R11 strobes vec%0d", v), {nand_we_n, nand_re_n},
          {VECS[v].we_n, VECS[v].re_n});
      if (!VECS[v].we_n)
        chk(nand_dq_oe && nand_dq_out == VECS[v].wd,
            $sformatf("R7 data vec%0d", v), {nand_dq_oe, nand_dq_out},
            {1'b1, VECS[v].wd});
      idle();
      @(negedge clk);
      @(negedge clk);
    end

    // R7 hold cycle after the write enable rises
    drive(1'b0, 1'b0, 1'b1, A_S0, 8'hC3);
    @(negedge clk);
    idle();
    chk(!nand_we_n && nand_dq_oe && nand_dq_out == 8'hC3, "R7 during write",
        {nand_we_n, nand_dq_oe, nand_dq_out}, {2'b01, 8'hC3});
    @(negedge clk);
    chk(nand_we_n && nand_dq_oe && nand_dq_out == 8'hC3, "R7 hold clock",
        {nand_we_n, nand_dq_oe, nand_dq_out}, {2'b11, 8'hC3});
    @(negedge clk);
    chk(!nand_dq_oe, "R7 release", nand_dq_oe, 0);

    // R8 flash read data path and non-status register offset
    nand_dq_in = 8'h5A;
    drive(1'b0, 1'b1, 1'b0, A_S1, 8'h00);
    @(negedge clk);
    chk(bus_rdata == 16'h005A, "R8 flash read", bus_rdata, 16'h005A);
    drive(1'b0, 1'b1, 1'b0, A_REG | 25'h4, 8'h00);
    @(negedge clk);
    chk(bus_rdata == 16'h0000, "R8 other offset", bus_rdata, 16'h0000);

    // R9 status follows the current slot (slot 1 busy, slot 0 ready)
    drive(1'b0, 1'b1, 1'b0, A_REG | 25'h2, 8'h00);
    @(negedge clk);
    chk(bus_rdata == 16'h0000, "R9 slot1 busy", bus_rdata, 16'h0000);
    drive(1'b0, 1'b1, 1'b0, A_S0, 8'h00);
    @(negedge clk);
    drive(1'b0, 1'b1, 1'b0, A_REG | 25'h2, 8'h00);
    @(negedge clk);
    chk(bus_rdata == 16'h0001, "R9 slot0 ready", bus_rdata, 16'h0001);
    nand_rb[0] = 1'b0;
    @(negedge clk);
    chk(bus_rdata == 16'h0001, "R9 edge1 old", bus_rdata, 16'h0001);
    @(negedge clk);
    chk(bus_rdata == 16'h0001, "R9 edge2 old", bus_rdata, 16'h0001);
    @(negedge clk);
    chk(bus_rdata == 16'h0000, "R9 edge3 new", bus_rdata, 16'h0000);
    idle();
    @(negedge clk);

    // R10 reset in the middle of a write
    drive(1'b0, 1'b0, 1'b1, A_S1 | 25'h20, 8'hEE);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(nand_ce_n == 2'b11 && nand_we_n && !nand_cle && !nand_dq_oe,
        "R10 reset mid write", {nand_ce_n, nand_we_n, nand_cle, nand_dq_oe},
        5'b11100);
    idle();
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule